// File: doc/BRIEF.md
# Segmented Address Generation and Protection Checker

This block forms a 64-bit virtual address from a 32-bit offset and a selected segment, and judges the access against that segment's descriptor. The descriptors live in a bank of six 64-bit registers, one for each segment. The bank is loaded through a plain write port and holds descriptors in an already-unpacked layout. Each access request names a segment, an offset, a length and the requester's privilege level. One cycle after the request is accepted, the block returns the virtual address and a fault code.

Requests enter through a valid/ready stream, and results leave through a second valid/ready stream. A result stays on the output until the consumer takes it. While an untaken result is held, `req_ready` is low, so upstream stalls. The write port is a plain control path with no handshake. It is sampled on every clock edge.

Top module: `seg_addr_check`

## Requirements
- R1: After reset, `res_valid` is 0, `req_ready` is 1 and every descriptor register is all zeros.
- R2: A write (`wr_en` = 1) with `wr_sel` 0..5 stores `wr_data` unchanged, with no check of its fields. A write with `wr_sel` 6 or 7 changes nothing. Segment index encoding: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R3: `res_va` is the 32-bit base (descriptor bits 31:0) plus the offset, taken modulo 2^32 and zero-extended to 64 bits.
- R4: If the present bit (bit 59) is 0, the result faults whatever the other fields hold. Fault codes are 0 none, 1 general protection, 2 stack. An SS access gets code 2 and any other segment gets code 1. This check wins over every other check.
- R5: For an SS access, the request privilege must equal the DPL (bits 58:57), or a stack fault results. For ES, DS, FS or GS, a privilege number above the DPL gives code 1. CS has no privilege check.
- R6: The effective limit is `{lim, 12'hFFF}` when bit 63 (granularity) is 1, and the raw 20-bit field (bits 51:32) when it is 0.
- R7: For an expand-up segment, the last byte offset (offset + `req_len_m1`, computed without wrap) must not exceed the effective limit. Otherwise the access faults, with code 2 on SS and code 1 elsewhere. This also covers fetches through CS.
- R8: A segment is expand-down when bit 56 (s) = 1, bit 55 = 0 and bit 54 = 1. For such a segment, an offset at or below the effective limit faults. A last byte above the upper bound also faults. The upper bound is 0xFFFF when bit 62 is 0 and 0xFFFFFFFF when bit 62 is 1.
- R9: A request with segment index 6 or 7 yields code 1, and its address uses a base of zero.
- R10: `req_ready` = !`res_valid` || `res_ready`. An accepted request shows its result with `res_valid` = 1 after the next clock edge. While `res_valid` = 1 and `res_ready` = 0, the result stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sel | input | 3 | Descriptor register index |
| wr_data | input | 64 | Descriptor value in unpacked layout |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_seg | input | 3 | Segment index of the access |
| req_ea | input | 32 | Effective offset |
| req_len_m1 | input | 3 | Access length in bytes minus one |
| req_cpl | input | 2 | Privilege level of the requester |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_va | output | 64 | Virtual address |
| res_fault | output | 2 | Fault code: 0 none, 1 general protection, 2 stack |

## Verification
Every result is due on the first rising edge after the cycle in which `req_valid` and `req_ready` are both high. The bench drives requests on the falling edge and reads the result on the following falling edge, which falls half a cycle after the registered result appears. Descriptor writes take effect at the edge they are sampled on. The bench therefore issues any request that depends on a write only after that edge has passed. In the back-pressure case the held result is read on each stalled falling edge. The next request's result is read one falling edge after `res_ready` rises.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 6;
  localparam int SEL_W   = 3;
  localparam int DESC_W  = 64;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = 12;

  localparam logic [SEL_W-1:0] SEG_ES = 3'd0;
  localparam logic [SEL_W-1:0] SEG_CS = 3'd1;
  localparam logic [SEL_W-1:0] SEG_SS = 3'd2;
  localparam logic [SEL_W-1:0] SEG_DS = 3'd3;
  localparam logic [SEL_W-1:0] SEG_FS = 3'd4;
  localparam logic [SEL_W-1:0] SEG_GS = 3'd5;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_GP    = 2'd1,
    FLT_STACK = 2'd2
  } fault_e;

  // unpacked descriptor layout, msb first
  typedef struct packed {
    logic             gran;
    logic             big;
    logic             ign;
    logic             avail;
    logic             present;
    logic [1:0]       dpl;
    logic             nonsys;
    logic [3:0]       kind;
    logic [LIM_W-1:0] lim;
    logic [31:0]      base;
  } desc_t;
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_pkg::*;
#(
  parameter int N = NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DESC_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output desc_t             rd_desc,
  output logic              rd_hit
);
  logic [DESC_W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs[i] <= '0;
      else if (wr_en && wr_sel == SEL_W'(i))      regs[i] <= wr_data;
    end

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(i)) |=> (regs[i] == $past(wr_data)));
    assert_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(i)) |=> $stable(regs[i]));
  end

  always_comb begin
    rd_desc = '0;
    rd_hit  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_desc = desc_t'(regs[i]);
        rd_hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_pkg::*;
#(
  parameter int EA_W  = 32,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  desc_t            desc,
  input  logic             seg_ok,
  input  logic             is_stack,
  input  logic             is_code,
  input  logic [EA_W-1:0]  ea,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [1:0]       cpl,
  output fault_e           fault,
  output logic [EA_W-1:0]  lin
);
  localparam int END_W = EA_W + 1;

  logic [EA_W-1:0]  lim_eff;
  logic [END_W-1:0] end_off;
  logic [END_W-1:0] upper;
  logic             exp_down, viol, priv_bad;
  fault_e           bad_code;

  always_comb begin
    lim_eff  = desc.gran ? {desc.lim, {GRAN_SH{1'b1}}} : {{GRAN_SH{1'b0}}, desc.lim};
    end_off  = {1'b0, ea} + END_W'(len_m1);
    exp_down = desc.nonsys && !desc.kind[3] && desc.kind[2];
    upper    = desc.big ? {1'b0, {EA_W{1'b1}}} : END_W'(17'h0FFFF);
    if (exp_down) viol = (ea <= lim_eff) || (end_off > upper);
    else          viol = end_off > {1'b0, lim_eff};
    priv_bad = is_stack ? (cpl != desc.dpl) : (!is_code && (cpl > desc.dpl));
    bad_code = is_stack ? FLT_STACK : FLT_GP;
    if (!seg_ok)            fault = FLT_GP;
    else if (!desc.present) fault = bad_code;
    else if (priv_bad)      fault = bad_code;
    else if (viol)          fault = bad_code;
    else                    fault = FLT_NONE;
    lin = (seg_ok ? desc.base : 32'd0) + ea;
  end

  assert_absent_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_ok && !desc.present) |-> (fault != FLT_NONE));
  assert_code_lacks_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_ok && is_code && desc.present && !viol) |-> (fault == FLT_NONE));
endmodule

// File: rtl/seg_result_stage.sv
module seg_result_stage
  import seg_pkg::*;
#(
  parameter int VA_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_va,
  input  fault_e          in_fault,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VA_W-1:0] out_va,
  output fault_e          out_fault
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_va    <= '0;
      out_fault <= FLT_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_va    <= in_va;
        out_fault <= in_fault;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_va) && $stable(out_fault)));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault != 2'd3));
endmodule

// File: rtl/seg_addr_check.sv
module seg_addr_check
  import seg_pkg::*;
#(
  parameter int EA_W  = 32,
  parameter int VA_W  = 64,
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DESC_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic [1:0]        req_cpl,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [VA_W-1:0]   res_va,
  output logic [1:0]        res_fault
);
  desc_t           cur_desc;
  logic            seg_ok;
  fault_e          chk_fault, out_fault;
  logic [EA_W-1:0] lin;
  logic [VA_W-1:0] va_next;

  seg_desc_bank #(.N(NUM_SEG)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(req_seg), .rd_desc(cur_desc), .rd_hit(seg_ok)
  );

  seg_access_check #(.EA_W(EA_W), .LEN_W(LEN_W)) u_check (
    .clk(clk), .rst_n(rst_n),
    .desc(cur_desc), .seg_ok(seg_ok),
    .is_stack(req_seg == SEG_SS), .is_code(req_seg == SEG_CS),
    .ea(req_ea), .len_m1(req_len_m1), .cpl(req_cpl),
    .fault(chk_fault), .lin(lin)
  );

  assign va_next = {{(VA_W-EA_W){1'b0}}, lin};

  seg_result_stage #(.VA_W(VA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_va(va_next), .in_fault(chk_fault),
    .out_valid(res_valid), .out_ready(res_ready),
    .out_va(res_va), .out_fault(out_fault)
  );

  assign res_fault = out_fault;

  assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !seg_ok) |=> (res_valid && res_fault == FLT_GP));
  assert_stack_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_seg == SEG_SS && !cur_desc.present)
      |=> (res_fault == FLT_STACK));
  assert_va_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_va[VA_W-1:EA_W] == '0));
endmodule

// File: tb/seg_addr_check_test.sv
module seg_addr_check_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [63:0] wr_data = 0;
  logic        req_valid = 0, req_ready;
  logic [2:0]  req_seg = 0;
  logic [31:0] req_ea = 0;
  logic [2:0]  req_len_m1 = 0;
  logic [1:0]  req_cpl = 0;
  logic        res_valid, res_ready = 1;
  logic [63:0] res_va;
  logic [1:0]  res_fault;

  int checks = 0, errors = 0;
  logic [63:0] model [6];

  seg_addr_check uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [31:0] base, logic [19:0] lim, logic [3:0] kind,
                                     logic s, logic [1:0] dpl, logic p, logic db, logic g);
    return {g, db, 1'b0, 1'b0, p, dpl, s, kind, lim, base};
  endfunction

  function automatic logic [1:0] ref_fault(logic [2:0] seg, logic [31:0] ea,
                                           logic [2:0] lm1, logic [1:0] cpl);
    logic [63:0] d; logic [31:0] lim; logic [32:0] e; logic ed, v; logic [1:0] bad;
    if (seg > 5) return 2'd1;
    d = model[seg];
    bad = (seg == 3'd2) ? 2'd2 : 2'd1;
    if (!d[59]) return bad;
    if (seg == 3'd2 && cpl != d[58:57]) return 2'd2;
    if (seg != 3'd1 && seg != 3'd2 && cpl > d[58:57]) return 2'd1;
    lim = d[63] ? {d[51:32], 12'hFFF} : {12'h0, d[51:32]};
    e = {1'b0, ea} + {30'd0, lm1};
    ed = d[56] && !d[55] && d[54];
    if (ed) v = (ea <= lim) || (e > (d[62] ? 33'h0FFFFFFFF : 33'h00000FFFF));
    else    v = e > {1'b0, lim};
    return v ? bad : 2'd0;
  endfunction

  function automatic logic [63:0] ref_va(logic [2:0] seg, logic [31:0] ea);
    logic [31:0] b;
    b = (seg > 5) ? 32'd0 : model[seg][31:0];
    return {32'd0, b + ea};
  endfunction

  task automatic wr(logic [2:0] sel, logic [63:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
    if (sel < 6) model[sel] = data;
  endtask

  task automatic send(string req, logic [2:0] seg, logic [31:0] ea, logic [2:0] lm1, logic [1:0] cpl);
    @(negedge clk);
    req_valid = 1; req_seg = seg; req_ea = ea; req_len_m1 = lm1; req_cpl = cpl; res_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, {63'd0, res_valid}, 64'd1);
    chk({req, " va"}, res_va, ref_va(seg, ea));
    chk({req, " fault"}, {62'd0, res_fault}, {62'd0, ref_fault(seg, ea, lm1, cpl)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) model[i] = '0;
    void'($urandom(32'h5EC0_0001));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    send("R1 zero desc DS", 3'd3, 32'h10, 0, 0);
    send("R1 zero desc SS", 3'd2, 32'h10, 0, 0);

    // R2: write stores unchecked data; index 7 ignored
    wr(3'd3, 64'h0000_0000_1234_5678);
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    send("R2 garbage descriptor DS", 3'd3, 32'h0, 0, 0);
    for (int i = 0; i < 6; i++) send("R2 index7 no effect", 3'(i), 32'h4, 0, 0);

    // R3: base plus offset wraps modulo 4G
    wr(3'd3, mk(32'hF000_0000, 20'hFFFFF, 4'h2, 1, 0, 1, 1, 1));
    send("R3 wrap", 3'd3, 32'h2000_0000, 0, 0);
    chk("R3 wrapped va", res_va, 64'h0000_0000_1000_0000);

    // R4: present priority over privilege and limit
    wr(3'd4, mk(32'h100, 20'h0, 4'h2, 1, 0, 0, 0, 0));
    send("R4 absent FS", 3'd4, 32'hFFFF, 3, 3);
    wr(3'd2, mk(32'h100, 20'hFFFFF, 4'h2, 1, 0, 0, 0, 1));
    send("R4 absent SS", 3'd2, 32'h0, 0, 0);
    chk("R4 stack code", {62'd0, res_fault}, 64'd2);

    // R5: privilege
    wr(3'd2, mk(32'h0, 20'hFFFFF, 4'h2, 1, 2, 1, 1, 1));
    send("R5 SS cpl match", 3'd2, 32'h40, 0, 2);
    send("R5 SS cpl mismatch", 3'd2, 32'h40, 0, 0);
    wr(3'd0, mk(32'h0, 20'hFFFFF, 4'h2, 1, 1, 1, 1, 1));
    send("R5 ES cpl above", 3'd0, 32'h40, 0, 2);
    send("R5 ES cpl below", 3'd0, 32'h40, 0, 0);
    wr(3'd1, mk(32'h0, 20'hFFFFF, 4'hA, 1, 0, 1, 1, 1));
    send("R5 CS no priv", 3'd1, 32'h40, 0, 3);

    // R6 and R7: granularity and expand-up limit
    wr(3'd5, mk(32'h0, 20'h1, 4'h2, 1, 3, 1, 0, 1));
    send("R6 g=1 last byte", 3'd5, 32'h1FFF, 0, 0);
    send("R7 g=1 crosses", 3'd5, 32'h1FFE, 2, 0);
    wr(3'd5, mk(32'h0, 20'h1FFF, 4'h2, 1, 3, 1, 0, 0));
    send("R6 g=0 at limit", 3'd5, 32'h1FFC, 3, 0);
    send("R6 g=0 past limit", 3'd5, 32'h2000, 0, 0);
    wr(3'd1, mk(32'h0, 20'h00FF, 4'hA, 1, 0, 1, 1, 0));
    send("R7 CS fetch over", 3'd1, 32'hFF, 1, 0);
    wr(3'd2, mk(32'h0, 20'h00FF, 4'h2, 1, 0, 1, 1, 0));
    send("R7 SS over", 3'd2, 32'h100, 0, 0);
    chk("R7 SS stack code", {62'd0, res_fault}, 64'd2);
    wr(3'd3, mk(32'h0, 20'hFFFFF, 4'h2, 1, 3, 1, 1, 1));
    send("R7 top of 4G wraps", 3'd3, 32'hFFFF_FFFE, 3, 0);

    // R8: expand-down
    wr(3'd3, mk(32'h0, 20'h100, 4'h6, 1, 3, 1, 0, 0));
    send("R8 at limit", 3'd3, 32'h100, 0, 0);
    send("R8 above limit", 3'd3, 32'h101, 0, 0);
    send("R8 top ok", 3'd3, 32'hFFFE, 1, 0);
    send("R8 past 64K", 3'd3, 32'hFFFF, 1, 0);
    wr(3'd3, mk(32'h0, 20'h100, 4'h6, 1, 3, 1, 1, 0));
    send("R8 big bound", 3'd3, 32'h10000, 3, 0);
    wr(3'd3, mk(32'h0, 20'h100, 4'hE, 1, 3, 1, 1, 0));
    send("R8 code not expand-down", 3'd3, 32'h100, 0, 0);

    // R9: bad index
    send("R9 index 6", 3'd6, 32'h1234, 0, 0);
    send("R9 index 7", 3'd7, 32'hABCD, 0, 0);

    // R10: back-pressure
    wr(3'd3, mk(32'h1000, 20'hFFFFF, 4'h2, 1, 3, 1, 1, 1));
    @(negedge clk);
    res_ready = 0; req_valid = 1; req_seg = 3; req_ea = 32'h11; req_len_m1 = 0; req_cpl = 0;
    @(negedge clk);
    chk("R10 first result", res_va, 64'h1011);
    chk("R10 ready low", {63'd0, req_ready}, 64'd0);
    req_ea = 32'h22;
    @(negedge clk);
    chk("R10 held va", res_va, 64'h1011);
    chk("R10 held valid", {63'd0, res_valid}, 64'd1);
    res_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 next result", res_va, 64'h1022);
    @(negedge clk);
    chk("R10 drained", {63'd0, res_valid}, 64'd0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] seg; logic [31:0] ea, lim; logic [1:0] cpl; logic [63:0] d;
      if (n % 6 == 0) begin
        d = {$urandom, $urandom};
        if ($urandom % 8 != 0) d[59] = 1;
        if ($urandom % 2) begin d[56] = 1; d[55] = 0; end
        wr(3'($urandom % 6), d);
      end
      seg = ($urandom % 16 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      lim = (seg < 6) ? (model[seg][63] ? {model[seg][51:32], 12'hFFF} : {12'h0, model[seg][51:32]}) : 32'h0;
      ea = ($urandom % 2) ? lim + 32'($urandom % 10) - 32'd5 : $urandom;
      cpl = (seg < 6 && $urandom % 4 != 0) ? model[seg][58:57] : 2'($urandom);
      send("R3-R9 random", seg, ea, 3'($urandom), cpl);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule